// File: doc/BRIEF.md
# Reserved-Address Sleep and Identification Handler

This block sits beside the bit-level engine of a two-wire serial (I2C) target and handles the reserved controller addresses. The engine reports byte-level events as single-cycle pulses: a START or repeated START, a received byte, the rising clock edge of the ninth (acknowledge) bit, and a STOP. The block answers with an acknowledge request for received bytes, or with a transmit byte while it owns the read data phase.

Two reserved sequences are decoded. Both begin with `F8h`, followed by the target's own device word, in which the read/write bit is ignored. A repeated START then carries either `F9h` or `86h`.

- `F9h` starts a read-only identification readout of three bytes, which repeats for as long as the controller keeps acknowledging.
- `86h` puts the target into a low-power sleep state. This is reported on `sleep_o`, and normal memory access is blocked while it is set.

While asleep, the block keeps watching the bus. A START followed by a matching device word wakes it at that word's acknowledge clock, and the word itself is left unacknowledged. A down-counter of `RECOV_CYC` system clock cycles then holds `ready_o` low. Until `ready_o` returns high, every reserved access is refused.

Top module: `rsv_sleep_id_ctrl`

## Requirements
- R1: After reset `sleep_o`=0, `ready_o`=1, `ack_o`=0 and `tx_en_o`=0.
- R2: When ready, a first byte `F8h` after a START is acknowledged. A following device word whose bits [7:4] are `1010` and bits [3:1] equal `strap_i` is acknowledged for either value of bit 0.
- R3: A device word after `F8h` that does not match is not acknowledged. The sequence is abandoned, so a later repeated START with `F9h` is not acknowledged and starts no readout.
- R4: After a repeated START, `F9h` is acknowledged. From its acknowledge clock `tx_en_o` is 1 and `tx_byte_o` is `00h`. Each controller ACK (`ctl_ack_i`=1 at `ack_clk_i`) advances the byte to `A3h` and then to `58h`.
- R5: A controller ACK after the third byte restarts the readout at `00h`. A controller NACK drops `tx_en_o` to 0.
- R6: After a repeated START, `86h` is acknowledged. `sleep_o` rises at that byte's acknowledge clock.
- R7: While asleep, a matching device word after a START is not acknowledged. At its acknowledge clock `sleep_o` falls, and `ready_o` stays 0 for exactly `RECOV_CYC` clock cycles before rising.
- R8: While asleep or recovering, `F8h` is not acknowledged. While asleep, a non-matching device word leaves the block asleep.
- R9: A STOP at any point returns the handler to idle with `ack_o`=0 and does not change `sleep_o`. A sequence broken by a STOP is not resumed.
- R10: A byte other than `F9h` or `86h` after the repeated START is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 3 | Device address straps |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| rx_valid_i | input | 1 | A byte from the controller is complete (pulse) |
| rx_byte_i | input | 8 | The received byte, MSB first on the wire |
| ack_clk_i | input | 1 | Rising SCL edge of the ninth bit (pulse) |
| ctl_ack_i | input | 1 | Controller acknowledged the sent byte (1 = SDA low) |
| ack_o | output | 1 | Drive ACK in the coming ninth bit |
| tx_en_o | output | 1 | Block owns the read data phase |
| tx_byte_o | output | 8 | Identification byte to transmit |
| sleep_o | output | 1 | Sleep state |
| ready_o | output | 1 | Normal access allowed |

## Verification
The embedded properties check the following on every cycle:
- No acknowledge is requested while asleep.
- A STOP always leaves the handler idle and the sleep flag unchanged.
- Sleep only rises on an acknowledge clock.
- Wake-up always drops `ready_o`.
- The readout index never leaves the three-byte range.

Only the directed scenarios can show the rest:
- The byte values and their wrap order.
- The exact length of the recovery window.
- That an abandoned or mismatched sequence refuses the later `F9h`.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam logic [7:0]  RSV_ENTRY = 8'hF8;
  localparam logic [7:0]  ID_CMD    = 8'hF9;
  localparam logic [7:0]  SLEEP_CMD = 8'h86;
  localparam logic [3:0]  DEV_TYPE  = 4'b1010;
  localparam int          MFR_W     = 12;
  localparam int          PROD_W    = 12;
  localparam logic [MFR_W-1:0]  MFR_ID  = 12'h00A;
  localparam logic [PROD_W-1:0] PROD_ID = 12'h358;
  localparam int          ID_W      = MFR_W + PROD_W;
  localparam int          ID_BYTES  = ID_W / 8;
  localparam int          IDX_W     = $clog2(ID_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DEV,
    ST_RS_WAIT,
    ST_CMD,
    ST_ID_ACK,
    ST_SLP_ACK,
    ST_ID_TX,
    ST_SLP_ADDR,
    ST_WAKE_ACK
  } rsv_st_e;
endpackage

// File: rtl/rsv_id_rom.sv
module rsv_id_rom
  import rsv_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  localparam logic [ID_W-1:0] ID_WORD = {MFR_ID, PROD_ID};

  logic [7:0] id_bytes [ID_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_byte
    assign id_bytes[g] = ID_WORD[ID_W-1-8*g -: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < ID_BYTES; i++) begin
      if (idx_i == IDX_W'(i)) byte_o = id_bytes[i];
    end
  end
endmodule

// File: rtl/rsv_pwr_state.sv
module rsv_pwr_state #(
  parameter int unsigned RECOV_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_set_i,
  input  logic wake_i,
  output logic sleep_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(RECOV_CYC + 1);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC);

  logic             sleep_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sleep_set_i) begin
      sleep_q <= 1'b1;
    end else if (wake_i) begin
      sleep_q <= 1'b0;
      cnt_q   <= RECOV_LD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sleep_o = sleep_q;
  assign ready_o = !sleep_q && (cnt_q == '0);

  // R7
  wake_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !sleep_o && !ready_o);
  // R7
  ready_after_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(sleep_q)) |-> ($past(cnt_q) == CNT_W'(1)));
endmodule

// File: rtl/rsv_seq_fsm.sv
module rsv_seq_fsm
  import rsv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       strap_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             ack_clk_i,
  input  logic             ctl_ack_i,
  input  logic             sleep_i,
  input  logic             ready_i,
  output logic             ack_o,
  output logic             tx_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sleep_set_o,
  output logic             wake_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_BYTES - 1);

  rsv_st_e          st_q;
  logic             ack_q;
  logic [IDX_W-1:0] idx_q;
  logic             dev_hit;
  logic             ack_evt;

  assign dev_hit = (rx_byte_i[7:4] == DEV_TYPE) && (rx_byte_i[3:1] == strap_i);
  assign ack_evt = ack_clk_i && !stop_i && !start_i && !rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      idx_q <= '0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else if (start_i) begin
      ack_q <= 1'b0;
      if (sleep_i)                 st_q <= ST_SLP_ADDR;
      else if (st_q == ST_RS_WAIT) st_q <= ST_CMD;
      else                         st_q <= ST_ADDR;
    end else if (rx_valid_i) begin
      ack_q <= 1'b0;
      st_q  <= ST_IDLE;
      unique case (st_q)
        ST_ADDR: if (rx_byte_i == RSV_ENTRY && ready_i) begin
          ack_q <= 1'b1;
          st_q  <= ST_DEV;
        end
        ST_DEV: if (dev_hit) begin
          ack_q <= 1'b1;
          st_q  <= ST_RS_WAIT;
        end
        ST_CMD: if (rx_byte_i == ID_CMD) begin
          ack_q <= 1'b1;
          st_q  <= ST_ID_ACK;
        end else if (rx_byte_i == SLEEP_CMD) begin
          ack_q <= 1'b1;
          st_q  <= ST_SLP_ACK;
        end
        ST_SLP_ADDR: if (dev_hit) st_q <= ST_WAKE_ACK;
        default: ;
      endcase
    end else if (ack_clk_i) begin
      ack_q <= 1'b0;
      unique case (st_q)
        ST_ID_ACK: begin
          st_q  <= ST_ID_TX;
          idx_q <= '0;
        end
        ST_ID_TX:
          if (ctl_ack_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          else           st_q  <= ST_IDLE;
        ST_SLP_ACK, ST_WAKE_ACK: st_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign tx_en_o     = (st_q == ST_ID_TX);
  assign idx_o       = idx_q;
  assign sleep_set_o = ack_evt && (st_q == ST_SLP_ACK);
  assign wake_o      = ack_evt && (st_q == ST_WAKE_ACK);

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE) && !ack_o);
  // R8
  no_ack_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !ack_o);
  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> (idx_q <= LAST));
  // R4
  tx_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> !sleep_i);
endmodule

// File: rtl/rsv_sleep_id_ctrl.sv
module rsv_sleep_id_ctrl
  import rsv_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] strap_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       ack_clk_i,
  input  logic       ctl_ack_i,
  output logic       ack_o,
  output logic       tx_en_o,
  output logic [7:0] tx_byte_o,
  output logic       sleep_o,
  output logic       ready_o
);
  logic [IDX_W-1:0] idx;
  logic             sleep_set;
  logic             wake;

  rsv_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .ack_clk_i  (ack_clk_i),
    .ctl_ack_i  (ctl_ack_i),
    .sleep_i    (sleep_o),
    .ready_i    (ready_o),
    .ack_o      (ack_o),
    .tx_en_o    (tx_en_o),
    .idx_o      (idx),
    .sleep_set_o(sleep_set),
    .wake_o     (wake)
  );

  rsv_id_rom u_rom (
    .idx_i (idx),
    .byte_o(tx_byte_o)
  );

  rsv_pwr_state #(.RECOV_CYC(RECOV_CYC)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_set_i(sleep_set),
    .wake_i     (wake),
    .sleep_o    (sleep_o),
    .ready_o    (ready_o)
  );

  // R9
  stop_keeps_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !ack_clk_i) |=> $stable(sleep_o));
  // R6
  sleep_on_ack_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(ack_clk_i));
endmodule

// File: tb/sim_rsv_sleep_id_ctrl.sv
module sim_rsv_sleep_id_ctrl;
  localparam int RC = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] strap_i = 3'b101;
  logic       start_i = 0, stop_i = 0, rx_valid_i = 0, ack_clk_i = 0, ctl_ack_i = 0;
  logic [7:0] rx_byte_i = '0;
  logic       ack_o, tx_en_o, sleep_o, ready_o;
  logic [7:0] tx_byte_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  rsv_sleep_id_ctrl #(.RECOV_CYC(RC)) u0 (.*);

  localparam logic [7:0] DEV_W = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, 3'b101, 1'b1};
  localparam logic [7:0] DEV_X = {4'b1010, 3'b011, 1'b0};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ev_start();
    start_i = 1; @(negedge clk_i); start_i = 0;
  endtask
  task automatic ev_stop();
    stop_i = 1; @(negedge clk_i); stop_i = 0;
  endtask
  task automatic ev_byte(input logic [7:0] b);
    rx_byte_i = b; rx_valid_i = 1; @(negedge clk_i); rx_valid_i = 0;
  endtask
  task automatic ev_ack(input logic a);
    ctl_ack_i = a; ack_clk_i = 1; @(negedge clk_i); ack_clk_i = 0; ctl_ack_i = 0;
  endtask

  task automatic prefix(input logic [7:0] dev);
    ev_start(); ev_byte(8'hF8); ev_ack(0);
    ev_byte(dev); ev_ack(0);
    ev_start();
  endtask

  task automatic t_reset();
    chk(sleep_o == 0, "R1 sleep", sleep_o, 0);
    chk(ready_o == 1, "R1 ready", ready_o, 1);
    chk(ack_o == 0 && tx_en_o == 0, "R1 ack/tx", {ack_o, tx_en_o}, 0);
  endtask

  task automatic t_id_read();
    ev_start(); ev_byte(8'hF8);
    chk(ack_o == 1, "R2 F8 ack", ack_o, 1);
    ev_ack(0);
    ev_byte(DEV_R);
    chk(ack_o == 1, "R2 dev ack rw=1", ack_o, 1);
    ev_ack(0); ev_start(); ev_byte(8'hF9);
    chk(ack_o == 1, "R4 F9 ack", ack_o, 1);
    ev_ack(0);
    chk(tx_en_o == 1 && tx_byte_o == 8'h00, "R4 byte0", {tx_en_o, tx_byte_o}, 9'h100);
    ev_ack(1);
    chk(tx_byte_o == 8'hA3, "R4 byte1", tx_byte_o, 8'hA3);
    ev_ack(1);
    chk(tx_byte_o == 8'h58, "R4 byte2", tx_byte_o, 8'h58);
    ev_ack(1);
    chk(tx_en_o == 1 && tx_byte_o == 8'h00, "R5 wrap", {tx_en_o, tx_byte_o}, 9'h100);
    ev_ack(0);
    chk(tx_en_o == 0, "R5 nack ends", tx_en_o, 0);
    ev_stop();
    ev_start(); ev_byte(8'hF8);
    chk(ack_o == 1, "R2 F8 ack again", ack_o, 1);
    ev_ack(0); ev_byte(DEV_W);
    chk(ack_o == 1, "R2 dev ack rw=0", ack_o, 1);
    ev_ack(0); ev_stop();
  endtask

  task automatic t_mismatch();
    ev_start(); ev_byte(8'hF8); ev_ack(0);
    ev_byte(DEV_X);
    chk(ack_o == 0, "R3 wrong dev nack", ack_o, 0);
    ev_ack(0); ev_start(); ev_byte(8'hF9);
    chk(ack_o == 0, "R3 F9 after abandon", ack_o, 0);
    ev_ack(0);
    chk(tx_en_o == 0, "R3 no readout", tx_en_o, 0);
    ev_stop();
  endtask

  task automatic t_bad_cmd();
    prefix(DEV_W); ev_byte(8'h55);
    chk(ack_o == 0, "R10 other cmd nack", ack_o, 0);
    ev_ack(0);
    chk(tx_en_o == 0 && sleep_o == 0, "R10 no effect", {tx_en_o, sleep_o}, 0);
    ev_stop();
  endtask

  task automatic t_stop_mid();
    ev_start(); ev_byte(8'hF8); ev_ack(0); ev_byte(DEV_W);
    ev_stop();
    chk(ack_o == 0, "R9 stop clears ack", ack_o, 0);
    ev_start(); ev_byte(8'h86);
    chk(ack_o == 0, "R9 not resumed", ack_o, 0);
    ev_ack(0);
    chk(sleep_o == 0, "R9 sleep unchanged", sleep_o, 0);
    ev_stop();
  endtask

  task automatic t_sleep();
    prefix(DEV_R); ev_byte(8'h86);
    chk(ack_o == 1 && sleep_o == 0, "R6 86 ack", {ack_o, sleep_o}, 2'b10);
    ev_ack(0);
    chk(sleep_o == 1 && ready_o == 0, "R6 asleep", {sleep_o, ready_o}, 2'b10);
    ev_stop();
    chk(sleep_o == 1, "R9 stop keeps sleep", sleep_o, 1);
  endtask

  task automatic t_asleep();
    ev_start(); ev_byte(8'hF8);
    chk(ack_o == 0, "R8 F8 nack asleep", ack_o, 0);
    ev_ack(0); ev_stop();
    ev_start(); ev_byte(DEV_X);
    chk(ack_o == 0, "R8 wrong dev nack", ack_o, 0);
    ev_ack(0);
    chk(sleep_o == 1, "R8 still asleep", sleep_o, 1);
    ev_stop();
    ev_start(); ev_byte(DEV_W); ev_stop();
    chk(sleep_o == 1, "R9 stop before wake clock", sleep_o, 1);
  endtask

  task automatic t_wake();
    ev_start(); ev_byte(DEV_R);
    chk(ack_o == 0 && sleep_o == 1, "R7 wake word nack", {ack_o, sleep_o}, 2'b01);
    ev_ack(0);
    chk(sleep_o == 0 && ready_o == 0, "R7 recovering", {sleep_o, ready_o}, 0);
    ev_stop(); ev_start(); ev_byte(8'hF8);
    chk(ack_o == 0, "R8 F8 nack recovering", ack_o, 0);
    ev_ack(0); ev_stop();
    repeat (RC - 6) @(negedge clk_i);
    chk(ready_o == 0, "R7 ready low at RC-1", ready_o, 0);
    @(negedge clk_i);
    chk(ready_o == 1, "R7 ready at RC", ready_o, 1);
    ev_start(); ev_byte(8'hF8);
    chk(ack_o == 1, "R2 F8 ack after recovery", ack_o, 1);
    ev_ack(0); ev_stop();
  endtask

  initial begin
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_id_read();
    t_mismatch();
    t_bad_cmd();
    t_stop_mid();
    t_sleep();
    t_asleep();
    t_wake();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule